// File: doc/BRIEF.md
# Vector length configuration unit

This unit carries out the set-vector-length operation of a vector-capable core. Each cycle that `valid_i` is high it takes a 32-bit instruction word and the contents of the general register named by the instruction's source field. From these and its own stored state it picks a new vector length (VL) and a new maximum vector length (MVL), clamps VL to MVL, and stores both. The stored state also holds a vertical-first mode bit.

The results appear on registered outputs one clock edge after the instruction is presented. They are the updated VL, MVL and mode bit, an optional register write-back of VL, and an optional update of the equal-zero condition flag. Register-file storage, pipelining and predication lie outside this block. Bit numbering of the instruction word treats bit 0 as its most significant bit, so MSB-0 bit `n` is `insn_i[31-n]`.

Top module: `vlc_unit`

## Requirements
- R1: While `rst_ni` is low, `vl_o`, `mvl_o` and `vf_o` are 0, and `wb_en_o` and `cr_we_o` are 0.
- R2: Fields use MSB-0 positions: destination bits 6..10 (`insn_i[25:21]`), source bits 11..15 (`insn_i[20:16]`), immediate bits 16..22 (`insn_i[15:9]`), vertical-first flag bit 23 (`insn_i[8]`), VL-select flag bit 24 (`insn_i[7]`), MVL-select flag bit 25 (`insn_i[6]`), record flag bit 31 (`insn_i[0]`).
- R3: The decoded immediate length is field + 1, so fields 0..63 give 1..64; fields 64..127 saturate to 64.
- R4: With VL-select set and a nonzero source field, the chosen VL is the register value, saturated to 64 when it exceeds 64 (any bit at or above bit 7 set counts as exceeding).
- R5: With VL-select set and a zero source field, the chosen VL is the decoded immediate.
- R6: With VL-select clear, the chosen VL is the stored VL.
- R7: With MVL-select set, the new MVL is the decoded immediate; otherwise it is the stored MVL.
- R8: The new VL is min(chosen VL, new MVL); both are stored and shown on `vl_o` and `mvl_o` after the edge.
- R9: When the destination field is nonzero, `wb_en_o` is 1, `wb_addr_o` is that field and `wb_data_o` is the new VL zero-extended; when it is zero, `wb_en_o` is 0.
- R10: When the record flag is 1, `cr_we_o` is 1 and `cr_eq_o` equals (new VL == 0); when it is 0, `cr_we_o` is 0.
- R11: `vf_o` is loaded from the instruction's vertical-first flag.
- R12: A cycle with `valid_i` low leaves `vl_o`, `mvl_o`, `vf_o` unchanged and drives `wb_en_o` and `cr_we_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| src_val_i | input | XLEN | Value of the register named by the source field |
| vl_o | output | 7 | Stored vector length |
| mvl_o | output | 7 | Stored maximum vector length |
| vf_o | output | 1 | Stored vertical-first mode bit |
| wb_en_o | output | 1 | Register write-back enable |
| wb_addr_o | output | 5 | Write-back register index |
| wb_data_o | output | XLEN | Write-back value (new VL) |
| cr_we_o | output | 1 | Equal-zero flag update enable |
| cr_eq_o | output | 1 | Equal-zero flag value |

## Verification
A corrupted stored VL or MVL stays hidden until an instruction reads it back: one with VL-select clear, or MVL-select clear. The wrong value then shows on `vl_o`, `wb_data_o` and `cr_eq_o` at the very next edge. The sequences therefore chain instructions that rely on held state right after ones that load it. A decode error on a field shows in the same cycle as a wrong source choice, a missing or stray write-back, or a flipped mode bit. Saturation and clamping faults show only with register values above 64, immediates at 0 and 63, and MVL below the chosen VL, so those cases are driven on purpose.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int INSN_W  = 32;
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 7;
  localparam int LEN_W   = 7;
  localparam int MAX_LEN = 64;

  // MSB-0 start positions of the fields
  localparam int DEST_POS = 6;
  localparam int SRC_POS  = 11;
  localparam int IMM_POS  = 16;
  localparam int VF_POS   = 23;
  localparam int VS_POS   = 24;
  localparam int MS_POS   = 25;
  localparam int RC_POS   = 31;

  // LSB-0 indices
  localparam int DEST_HI = INSN_W - 1 - DEST_POS;
  localparam int SRC_HI  = INSN_W - 1 - SRC_POS;
  localparam int IMM_HI  = INSN_W - 1 - IMM_POS;
  localparam int VF_BIT  = INSN_W - 1 - VF_POS;
  localparam int VS_BIT  = INSN_W - 1 - VS_POS;
  localparam int MS_BIT  = INSN_W - 1 - MS_POS;
  localparam int RC_BIT  = INSN_W - 1 - RC_POS;

  typedef logic [LEN_W-1:0] len_t;

  typedef struct packed {
    logic [REG_AW-1:0] dest;
    logic [REG_AW-1:0] src;
    logic [IMM_W-1:0]  imm;
    logic              vf;
    logic              vs;
    logic              ms;
    logic              rc;
  } vlc_fields_t;
endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
  import vlc_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output vlc_fields_t       fld_o
);
  always_comb begin
    fld_o.dest = insn_i[DEST_HI -: REG_AW];
    fld_o.src  = insn_i[SRC_HI -: REG_AW];
    fld_o.imm  = insn_i[IMM_HI -: IMM_W];
    fld_o.vf   = insn_i[VF_BIT];
    fld_o.vs   = insn_i[VS_BIT];
    fld_o.ms   = insn_i[MS_BIT];
    fld_o.rc   = insn_i[RC_BIT];
  end

  logic unused_bits;
  assign unused_bits = ^{insn_i[INSN_W-1:DEST_HI+1], insn_i[MS_BIT-1:RC_BIT+1]};
endmodule

// File: rtl/vlc_select.sv
module vlc_select
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   src_val_i,
  input  logic [REG_AW-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              vs_i,
  input  logic              ms_i,
  input  len_t              vl_q_i,
  input  len_t              mvl_q_i,
  output len_t              vl_n_o,
  output len_t              mvl_n_o
);
  localparam len_t MAX_L = len_t'(MAX_LEN);

  logic [IMM_W:0] imm_ext;
  len_t           imm_len;
  len_t           reg_len;
  len_t           vl_pick;

  // field+1, capped at MAX_LEN
  assign imm_ext = {1'b0, imm_i} + 1'b1;
  assign imm_len = (imm_ext > (IMM_W+1)'(MAX_LEN)) ? MAX_L : imm_ext[LEN_W-1:0];

  generate
    if (XLEN > LEN_W) begin : g_wide
      logic upper_set;
      assign upper_set = |src_val_i[XLEN-1:LEN_W];
      assign reg_len   = (upper_set || (src_val_i[LEN_W-1:0] > MAX_L))
                         ? MAX_L : src_val_i[LEN_W-1:0];
    end else begin : g_narrow
      len_t low;
      assign low     = len_t'(src_val_i);
      assign reg_len = (low > MAX_L) ? MAX_L : low;
    end
  endgenerate

  always_comb begin
    if (!vs_i)              vl_pick = vl_q_i;
    else if (src_i != '0)   vl_pick = reg_len;
    else                    vl_pick = imm_len;
    mvl_n_o = ms_i ? imm_len : mvl_q_i;
    vl_n_o  = (vl_pick < mvl_n_o) ? vl_pick : mvl_n_o;
  end
endmodule

// File: rtl/vlc_state.sv
module vlc_state
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  vlc_fields_t       fld_i,
  input  len_t              vl_n_i,
  input  len_t              mvl_n_i,
  output len_t              vl_q_o,
  output len_t              mvl_q_o,
  output logic              vf_q_o,
  output logic              wb_en_o,
  output logic [REG_AW-1:0] wb_addr_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              cr_we_o,
  output logic              cr_eq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q_o  <= '0;
      mvl_q_o <= '0;
      vf_q_o  <= 1'b0;
    end else if (valid_i) begin
      vl_q_o  <= vl_n_i;
      mvl_q_o <= mvl_n_i;
      vf_q_o  <= fld_i.vf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= 1'b0;
      wb_addr_o <= '0;
      wb_data_o <= '0;
      cr_we_o   <= 1'b0;
      cr_eq_o   <= 1'b0;
    end else begin
      wb_en_o <= valid_i && (fld_i.dest != '0);
      cr_we_o <= valid_i && fld_i.rc;
      if (valid_i) begin
        wb_addr_o <= fld_i.dest;
        wb_data_o <= XLEN'(vl_n_i);
        cr_eq_o   <= (vl_n_i == '0);
      end
    end
  end

  logic unused_fld;
  assign unused_fld = ^{fld_i.src, fld_i.imm, fld_i.vs, fld_i.ms};
endmodule

// File: rtl/vlc_unit.sv
module vlc_unit
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [INSN_W-1:0]     insn_i,
  input  logic [XLEN-1:0]       src_val_i,
  output logic [LEN_W-1:0]      vl_o,
  output logic [LEN_W-1:0]      mvl_o,
  output logic                  vf_o,
  output logic                  wb_en_o,
  output logic [REG_AW-1:0]     wb_addr_o,
  output logic [XLEN-1:0]       wb_data_o,
  output logic                  cr_we_o,
  output logic                  cr_eq_o
);
  vlc_fields_t fld;
  len_t        vl_n, mvl_n;

  vlc_decode u_dec (
    .insn_i (insn_i),
    .fld_o  (fld)
  );

  vlc_select #(.XLEN(XLEN)) u_sel (
    .src_val_i (src_val_i),
    .src_i     (fld.src),
    .imm_i     (fld.imm),
    .vs_i      (fld.vs),
    .ms_i      (fld.ms),
    .vl_q_i    (vl_o),
    .mvl_q_i   (mvl_o),
    .vl_n_o    (vl_n),
    .mvl_n_o   (mvl_n)
  );

  vlc_state #(.XLEN(XLEN)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .fld_i     (fld),
    .vl_n_i    (vl_n),
    .mvl_n_i   (mvl_n),
    .vl_q_o    (vl_o),
    .mvl_q_o   (mvl_o),
    .vf_q_o    (vf_o),
    .wb_en_o   (wb_en_o),
    .wb_addr_o (wb_addr_o),
    .wb_data_o (wb_data_o),
    .cr_we_o   (cr_we_o),
    .cr_eq_o   (cr_eq_o)
  );
endmodule

// File: rtl/vlc_unit_chk.sv
module vlc_unit_chk
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [INSN_W-1:0] insn_i,
  input logic [LEN_W-1:0]  vl_o,
  input logic [LEN_W-1:0]  mvl_o,
  input logic              vf_o,
  input logic              wb_en_o,
  input logic [REG_AW-1:0] wb_addr_o,
  input logic [XLEN-1:0]   wb_data_o,
  input logic              cr_we_o,
  input logic              cr_eq_o
);
  assert_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= mvl_o);

  assert_mvl_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mvl_o <= LEN_W'(MAX_LEN));

  assert_no_write_r0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_addr_o != '0));

  assert_wb_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_data_o == XLEN'(vl_o)));

  assert_cr_eq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (cr_eq_o == (vl_o == '0)));

  assert_vf_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (vf_o == $past(insn_i[VF_BIT])));

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(vl_o) && $stable(mvl_o) && $stable(vf_o)));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wb_en_o && !cr_we_o));
endmodule

bind vlc_unit vlc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .vl_o      (vl_o),
  .mvl_o     (mvl_o),
  .vf_o      (vf_o),
  .wb_en_o   (wb_en_o),
  .wb_addr_o (wb_addr_o),
  .wb_data_o (wb_data_o),
  .cr_we_o   (cr_we_o),
  .cr_eq_o   (cr_eq_o)
);

// File: tb/sim_vlc_unit.sv
`timescale 1ns/1ps
module sim_vlc_unit;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [31:0]     insn = '0;
  logic [XLEN-1:0] src_val = '0;
  logic [6:0]      vl, mvl;
  logic            vf, wb_en, cr_we, cr_eq;
  logic [4:0]      wb_addr;
  logic [XLEN-1:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vlc_unit #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .src_val_i(src_val), .vl_o(vl), .mvl_o(mvl), .vf_o(vf),
    .wb_en_o(wb_en), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .cr_we_o(cr_we), .cr_eq_o(cr_eq)
  );

  typedef struct packed {
    logic [6:0]      vl;
    logic [6:0]      mvl;
    logic            vf;
    logic            wb_en;
    logic [4:0]      addr;
    logic [XLEN-1:0] data;
    logic            cr_we;
    logic            cr_eq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // reference state
  int m_vl = 0, m_mvl = 0;
  bit m_vf = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int dest, input int src, input int imm,
                                     input bit f_vf, input bit f_vs, input bit f_ms,
                                     input bit f_rc);
    logic [31:0] w = '0;
    w[25:21] = dest[4:0];
    w[20:16] = src[4:0];
    w[15:9]  = imm[6:0];
    w[8] = f_vf; w[7] = f_vs; w[6] = f_ms; w[0] = f_rc;
    return w;
  endfunction

  task automatic apply(input bit v, input logic [31:0] w, input logic [XLEN-1:0] r,
                       input string tag);
    exp_t e;
    int imm_len, pick, reg_len;
    @(negedge clk);
    valid = v; insn = w; src_val = r;
    e = '0;
    if (v) begin
      imm_len = int'(w[15:9]) + 1;
      if (imm_len > 64) imm_len = 64;
      reg_len = (r > 64) ? 64 : int'(r[6:0]);
      if (!w[7])              pick = m_vl;
      else if (w[20:16] != 0) pick = reg_len;
      else                    pick = imm_len;
      if (w[6]) m_mvl = imm_len;
      m_vl = (pick < m_mvl) ? pick : m_mvl;
      m_vf = w[8];
      e.wb_en = (w[25:21] != 0);
      e.addr  = w[25:21];
      e.data  = XLEN'(m_vl);
      e.cr_we = w[0];
      e.cr_eq = (m_vl == 0);
    end
    e.vl  = 7'(m_vl);
    e.mvl = 7'(m_mvl);
    e.vf  = m_vf;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(vl == e.vl,       t, "vl",    XLEN'(vl),    XLEN'(e.vl));
      chk(mvl == e.mvl,     t, "mvl",   XLEN'(mvl),   XLEN'(e.mvl));
      chk(vf == e.vf,       t, "vf",    XLEN'(vf),    XLEN'(e.vf));
      chk(wb_en == e.wb_en, t, "wb_en", XLEN'(wb_en), XLEN'(e.wb_en));
      if (e.wb_en) begin
        chk(wb_addr == e.addr, t, "wb_addr", XLEN'(wb_addr), XLEN'(e.addr));
        chk(wb_data == e.data, t, "wb_data", wb_data, e.data);
      end
      chk(cr_we == e.cr_we, t, "cr_we", XLEN'(cr_we), XLEN'(e.cr_we));
      if (e.cr_we)
        chk(cr_eq == e.cr_eq, t, "cr_eq", XLEN'(cr_eq), XLEN'(e.cr_eq));
    end
  end

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    valid = 1'b1; insn = mk(3, 0, 10, 1, 1, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(vl == 0 && mvl == 0 && vf == 0, "R1", "state in reset",
        XLEN'({vl, mvl, vf}), 0);
    chk(!wb_en && !cr_we, "R1", "strobes in reset", XLEN'({wb_en, cr_we}), 0);
    valid = 1'b0;
    rst_n = 1'b1;

    apply(1, mk(3, 0, 63, 0, 1, 1, 1), 0, "R3 R5 R7 imm 63");
    apply(1, mk(4, 0, 0, 0, 1, 0, 1), 0, "R3 R5 imm 0");
    apply(1, mk(5, 7, 0, 0, 1, 0, 0), 64'd10, "R4 reg 10");
    apply(1, mk(6, 7, 0, 1, 1, 0, 1), 64'd1000, "R4 reg saturate");
    apply(1, mk(6, 7, 0, 0, 1, 0, 0), 64'h1_0000_0003, "R4 upper bits");
    apply(1, mk(7, 9, 0, 0, 1, 0, 1), 64'd65, "R4 reg 65");
    apply(1, mk(8, 9, 0, 0, 1, 0, 1), 64'd0, "R10 vl zero");
    apply(1, mk(9, 9, 0, 0, 1, 0, 0), 64'd40, "R4 reg 40");
    apply(1, mk(10, 3, 5, 0, 0, 0, 1), 64'd2, "R6 held");
    apply(1, mk(11, 0, 7, 1, 0, 1, 1), 0, "R7 R8 clamp to 8");
    apply(1, mk(0, 0, 30, 1, 1, 0, 1), 0, "R9 dest zero");
    apply(0, mk(12, 0, 2, 0, 1, 1, 1), 0, "R12 idle");
    apply(0, '1, '1, "R12 idle ones");
    apply(1, mk(31, 0, 100, 0, 0, 1, 0), 0, "R3 imm 100");
    apply(1, mk(13, 17, 20, 1, 1, 1, 0), 64'd50, "R2 R8 reg over mvl");
    apply(1, mk(1, 0, 5, 0, 1, 0, 1), 64'd9, "R5 src zero ignores reg");
    apply(1, mk(2, 2, 0, 1, 0, 0, 0), 64'd3, "R6 R11 held vf");
    apply(1, mk(20, 20, 31, 0, 1, 1, 1), 64'd32, "R8 equal");
    apply(0, 0, 0, "R12 drain");
    apply(0, 0, 0, "R12 drain");
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule